// File: doc/BRIEF.md
# Saturating Transmit Event Statistics

This block counts transmit outcomes for an Ethernet MAC and reports them through one 16-bit read-only statistics word. The transmit engine reports each packet once, when the packet is finished. It supplies a completion strobe, the number of collisions the packet saw, a flag for a deferred start and a flag for excessive deferral. From these the block advances up to four independent 4-bit counters. A packet can advance each counter by at most one, so one packet with many retries or many deferrals still counts once.

The counters never wrap. A counter that reaches 15 stays at 15, and the block then raises a level interrupt so that the host collects the statistics before more events are lost. When the host reads the word, it gets the current value in that cycle. All four counters then return to zero. If a packet completes in the same cycle as the read, the counters start again from that packet's increments, so no event is lost.

The interrupt comes from a two-state machine. In `IRQ_QUIET` the request is low. The transition *arm* (some counter becomes 15 at the next edge) moves it to `IRQ_RAISED`. In `IRQ_RAISED` the request is high. The transition *release* (a read leaves no counter at 15) moves it back to `IRQ_QUIET`. If neither transition fires, the machine stays in its current state.

Top module: `tsc_tx_stats`

## Requirements
- R1: After reset, all four counters read zero and the interrupt request is low.
- R2: The statistics word is laid out as follows: single-collision count in bits 3:0, multiple-collision count in bits 7:4, deferred count in bits 11:8 and excessive-deferral count in bits 15:12.
- R3: A completed packet with a collision count of exactly 1 increments the single-collision counter and leaves the multiple-collision counter unchanged.
- R4: A completed packet with a collision count from 2 to 16 increments only the multiple-collision counter. A count of 0, or any count above 16, changes neither collision counter.
- R5: A completed packet with the deferred flag set increments the deferred counter by exactly one. No counter moves by more than one per packet.
- R6: The excessive-deferral flag increments its own counter, independently of the deferred flag.
- R7: A counter at 15 stays at 15 when further events arrive and never wraps.
- R8: The interrupt request is high in exactly those cycles in which some counter reads 15. It falls in the cycle after a read that clears the counters.
- R9: During a read strobe, the word shows the value from before the read. In the next cycle all counters read zero.
- R10: If a read and a packet completion occur in the same cycle, the counters restart from zero plus that packet's increments.
- R11: Without the completion strobe, the collision count and the deferral flags have no effect. Without a read, the word stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_done_i | input | 1 | One-cycle strobe, once per finished packet |
| tx_coll_i | input | 5 | Collisions seen by the finished packet (0 to 31) |
| tx_defer_i | input | 1 | Finished packet was deferred at least once |
| tx_xdefer_i | input | 1 | Finished packet hit excessive deferral |
| rd_i | input | 1 | Host read strobe of the statistics word |
| stat_o | output | 16 | Packed counter word |
| irq_o | output | 1 | Level interrupt request, high while any counter is full |

## Verification
The bench targets the edges of the collision classification: 0, 1, 2, 16 and 17 collisions. A design with an off-by-one boundary would count a lone collision as a multiple collision, or would count an aborted packet. It drives a counter past 15. A design that wraps would fall back to zero and drop the interrupt. It also puts a read and a completion in the same cycle. A design with the wrong priority would either lose that packet's increments or fail to clear the counters. Finally, it drives the flags while the completion strobe is low, to catch a design that counts without the strobe.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    // Slot order inside the statistics word (low slot = low bits).
    localparam int SLOT_SINGLE = 0;
    localparam int SLOT_MULTI  = 1;
    localparam int SLOT_DEFER  = 2;
    localparam int SLOT_XDEFER = 3;
    localparam int SLOT_COUNT  = 4;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/tsc_classify.sv
module tsc_classify
    import tsc_pkg::*;
#(
    parameter int COLL_W    = 5,
    parameter int MULTI_MAX = 16
) (
    input  logic              tx_done_i,
    input  logic [COLL_W-1:0] tx_coll_i,
    input  logic              tx_defer_i,
    input  logic              tx_xdefer_i,
    output logic [SLOT_COUNT-1:0] inc_o
);
    localparam logic [COLL_W-1:0] ONE_COLL = COLL_W'(1);
    localparam logic [COLL_W-1:0] TWO_COLL = COLL_W'(2);
    localparam logic [COLL_W-1:0] TOP_COLL = COLL_W'(MULTI_MAX);

    logic is_single;
    logic is_multi;

    always_comb begin
        is_single = (tx_coll_i == ONE_COLL);
        is_multi  = (tx_coll_i >= TWO_COLL) && (tx_coll_i <= TOP_COLL);
    end

    always_comb begin
        inc_o              = '0;
        inc_o[SLOT_SINGLE] = tx_done_i && is_single;
        inc_o[SLOT_MULTI]  = tx_done_i && is_multi;
        inc_o[SLOT_DEFER]  = tx_done_i && tx_defer_i;
        inc_o[SLOT_XDEFER] = tx_done_i && tx_xdefer_i;
    end
endmodule

// File: rtl/tsc_sat_counter.sv
module tsc_sat_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             full_nxt_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;
    logic [WIDTH-1:0] base;

    always_comb begin
        base = clr_i ? '0 : cnt_q;
        if (inc_i && (base != TOP)) cnt_d = base + WIDTH'(1);
        else                        cnt_d = base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o      = cnt_q;
    assign full_nxt_o = (cnt_d == TOP);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) && !clr_i |=> (cnt_q == TOP));

    assert_one_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + WIDTH'(1)));

    assert_clear_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q <= WIDTH'(1)));
endmodule

// File: rtl/tsc_irq_fsm.sv
module tsc_irq_fsm
    import tsc_pkg::*;
#(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] full_nxt_i,
    input  logic [NUM-1:0] full_now_i,
    output logic           irq_o
);
    irq_state_e state_q, state_d;
    logic any_full_nxt;

    assign any_full_nxt = |full_nxt_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_full_nxt)  state_d = IRQ_RAISED; // arm
            IRQ_RAISED: if (!any_full_nxt) state_d = IRQ_QUIET;  // release
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            IRQ_QUIET:  irq_o = 1'b0;
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|full_now_i));
endmodule

// File: rtl/tsc_tx_stats.sv
module tsc_tx_stats
    import tsc_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int COLL_W    = 5,
    parameter int MULTI_MAX = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tx_done_i,
    input  logic [COLL_W-1:0]         tx_coll_i,
    input  logic                      tx_defer_i,
    input  logic                      tx_xdefer_i,
    input  logic                      rd_i,
    output logic [SLOT_COUNT*CNT_W-1:0] stat_o,
    output logic                      irq_o
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [SLOT_COUNT-1:0] inc;
    logic [SLOT_COUNT-1:0] full_nxt;
    logic [SLOT_COUNT-1:0] full_now;

    tsc_classify #(
        .COLL_W   (COLL_W),
        .MULTI_MAX(MULTI_MAX)
    ) u_classify (
        .tx_done_i  (tx_done_i),
        .tx_coll_i  (tx_coll_i),
        .tx_defer_i (tx_defer_i),
        .tx_xdefer_i(tx_xdefer_i),
        .inc_o      (inc)
    );

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_cnt
        tsc_sat_counter #(.WIDTH(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc[g]),
            .clr_i     (rd_i),
            .cnt_o     (stat_o[g*CNT_W +: CNT_W]),
            .full_nxt_o(full_nxt[g])
        );
        assign full_now[g] = (stat_o[g*CNT_W +: CNT_W] == TOP);
    end

    tsc_irq_fsm #(.NUM(SLOT_COUNT)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_nxt_i(full_nxt),
        .full_now_i(full_now),
        .irq_o     (irq_o)
    );

    assert_class_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc[SLOT_SINGLE], inc[SLOT_MULTI]}));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done_i && !rd_i |=> $stable(stat_o));

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && !tx_done_i |=> (stat_o == '0));
endmodule

// File: tb/tb_tsc_tx_stats.sv
`timescale 1ns/1ps
module tb_tsc_tx_stats;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_done = 1'b0;
    logic [4:0]  tx_coll = '0;
    logic        tx_defer = 1'b0;
    logic        tx_xdefer = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] stat;
    logic        irq;

    always #2 clk = ~clk;

    tsc_tx_stats dut (
        .clk(clk), .rst_n(rst_n), .tx_done_i(tx_done), .tx_coll_i(tx_coll),
        .tx_defer_i(tx_defer), .tx_xdefer_i(tx_xdefer), .rd_i(rd),
        .stat_o(stat), .irq_o(irq)
    );

    typedef struct {
        logic [15:0] word;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    event item_ev;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    int   m[4] = '{0, 0, 0, 0};

    function automatic logic [15:0] pack_model();
        return {4'(m[3]), 4'(m[2]), 4'(m[1]), 4'(m[0])};
    endfunction

    function automatic logic irq_model();
        return (m[0] == 15) || (m[1] == 15) || (m[2] == 15) || (m[3] == 15);
    endfunction

    task automatic push(input string tag);
        exp_t e;
        e.word = pack_model();
        e.irq  = irq_model();
        e.tag  = tag;
        q.push_back(e);
        -> item_ev;
    endtask

    // Monitor: compares design outputs with queued expectations.
    initial begin
        forever begin
            @(item_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (stat !== e.word || irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                             e.tag, stat, irq, e.word, e.irq);
                end
            end
        end
    end

    // Driver: one cycle of stimulus, model update, expectation push.
    task automatic step(input bit tx, input int coll, input bit df, input bit ex,
                        input bit rdx, input string tag);
        @(negedge clk);
        tx_done = tx; tx_coll = 5'(coll); tx_defer = df; tx_xdefer = ex; rd = rdx;
        #0;
        if (rdx) push({tag, " read-old-value R9"});
        if (rdx) m = '{0, 0, 0, 0};
        if (tx) begin
            if (coll == 1) m[0]++;
            else if (coll >= 2 && coll <= 16) m[1]++;
            if (df) m[2]++;
            if (ex) m[3]++;
            for (int i = 0; i < 4; i++) if (m[i] > 15) m[i] = 15;
        end
        @(posedge clk);
        #1;
        tx_done = 0; tx_coll = '0; tx_defer = 0; tx_xdefer = 0; rd = 0;
        push(tag);
    endtask

    initial begin
        #(4 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        push("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 1, 0, 0, 0, "R3 single collision, R2 layout");
        step(1, 2, 0, 0, 0, "R4 two collisions");
        step(1, 16, 0, 0, 0, "R4 sixteen collisions");
        step(1, 0, 0, 0, 0, "R4 zero collisions");
        step(1, 17, 0, 0, 0, "R4 seventeen collisions");
        step(1, 5, 1, 0, 0, "R5 deferred once");
        step(1, 0, 0, 1, 0, "R6 excessive deferral alone");
        step(1, 1, 1, 1, 0, "R5 R6 all flags one packet");
        step(0, 1, 1, 1, 0, "R11 flags without strobe");
        step(0, 3, 0, 1, 0, "R11 flags without strobe again");
        step(0, 0, 0, 0, 1, "R9 plain read");
        step(0, 0, 0, 0, 0, "R9 idle after read");

        for (int i = 0; i < 18; i++) step(1, 1, 0, 0, 0, "R7 R8 drive single to saturation");
        step(0, 0, 0, 0, 0, "R8 irq holds while full");
        step(1, 1, 0, 0, 1, "R10 read with packet");
        step(0, 0, 0, 0, 0, "R8 irq dropped after read");

        for (int i = 0; i < 15; i++) step(1, 9, 1, 0, 0, "R7 fill multi and defer");
        step(1, 9, 1, 1, 0, "R7 saturated hold");
        step(1, 0, 1, 1, 1, "R10 read with deferred packet");
        step(0, 0, 0, 0, 1, "R9 second read");
        step(0, 0, 0, 0, 0, "R1 back to zero");

        repeat (2) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule